// File: doc/BRIEF.md
# Two-Level UVLO Startup Sequencer

This block decides when a flyback controller may switch. It controls the high-voltage startup current source that charges the supply capacitor, and it asserts a run enable once the supply has reached its turn-on level and the line has passed its brown-in level. It also produces an 8-bit soft-start value that ramps evenly while run is asserted. All analog thresholds arrive as comparator flags.

Once switching stops because the supply collapsed, the startup source stays off until the supply has drained below a lower recharge level. Only then does it charge toward the turn-on level again. This two-level restart keeps the average power low while a fault persists. A line brownout must last a debounce window before switching stops. The window is longer while the converter reports light load. Recovery from a brownout is blocked while the supply sits below the AC-recovery level. A latched fault holds run low until the supply falls below the latch-release level.

States: CHARGE (source on), RUN (switching), BROWN (line lost, supply still up), DRAIN (both off, waiting for the recharge level), LATCH (fault held). Transitions:
- CHARGE→RUN
- RUN→DRAIN
- RUN→BROWN
- BROWN→RUN
- BROWN→DRAIN
- DRAIN→CHARGE
- any of CHARGE, RUN, BROWN or DRAIN → LATCH when a fault is latched
- LATCH→CHARGE

Top module: `uvlo_startup_seq`

## Requirements
- R1: After reset the block is in CHARGE: hv_src_en=1, run_en=0, ss_level=0.
- R2: CHARGE goes to RUN on the first clock edge where vdd_above_on=1 and line_above_brownin=1 both hold. After that edge run_en=1 and hv_src_en=0. Either flag alone keeps the block in CHARGE.
- R3: In RUN, vdd_below_off=1 at a clock edge moves the block to DRAIN, with run_en=0 and hv_src_en=0 after that edge.
- R4: In DRAIN, hv_src_en stays 0 until an edge with vdd_below_recharge=1. That edge moves the block to CHARGE, with hv_src_en=1.
- R5: In RUN with light_load=0, run_en falls after exactly BO_NORM_CYC consecutive edges that sample line_below_brownout=1. The block then enters BROWN.
- R6: With light_load=1 the brownout window is BO_LIGHT_CYC consecutive edges instead.
- R7: A brownout pulse shorter than the window leaves run_en=1, and the count restarts from zero.
- R8: BROWN returns to RUN only on an edge with line_above_brownin=1 and vdd_below_acrec=0. While vdd_below_acrec=1, run_en stays 0.
- R9: In BROWN, vdd_below_off=1 moves the block to DRAIN.
- R10: While run_en=1, ss_level rises by one every SS_STEP_CYC edges, starting at 0 on entry to RUN, and saturates at 255.
- R11: ss_level returns to 0 on the edge after run_en goes low.
- R12: fault_latched=1 moves the block to LATCH, with run_en=0 and hv_src_en=0. In LATCH the supply flags are ignored until an edge with vdd_below_release=1, which moves the block to CHARGE.
- R13: hv_src_en and run_en are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vdd_above_on | input | 1 | Supply at or above turn-on level |
| vdd_below_off | input | 1 | Supply below turn-off level |
| vdd_below_recharge | input | 1 | Supply below protection recharge level |
| vdd_below_release | input | 1 | Supply below latch-release level |
| vdd_below_acrec | input | 1 | Supply below AC-recovery level |
| line_above_brownin | input | 1 | Line above brown-in level |
| line_below_brownout | input | 1 | Line below brownout level |
| light_load | input | 1 | Light-load mode flag |
| fault_latched | input | 1 | A protection latch is set |
| hv_src_en | output | 1 | Startup current source enable |
| run_en | output | 1 | Switching enable |
| ss_level | output | 8 | Soft-start ramp value |

## Verification
The assertions check several rules on every cycle:
- the startup source and run are never both enabled;
- a latched fault forces run low on the next cycle;
- DRAIN exits only after the recharge flag;
- a return from BROWN never happens while the AC-recovery flag is set;
- the soft-start value clears after run drops and never falls while run holds.

Only the bench scenarios can show the exact debounce lengths in both load modes, the restart after a short brownout glitch, the ramp step spacing and its saturation, and the full latch-release sequence.

// File: rtl/uvlo_seq_pkg.sv
package uvlo_seq_pkg;
    typedef enum logic [2:0] {
        ST_CHARGE = 3'd0,
        ST_RUN    = 3'd1,
        ST_BROWN  = 3'd2,
        ST_DRAIN  = 3'd3,
        ST_LATCH  = 3'd4
    } seq_state_t;
endpackage

// File: rtl/uvlo_brown_debounce.sv
module uvlo_brown_debounce #(
    parameter int NORM_CYC  = 9_375_000,
    parameter int LIGHT_CYC = 29_375_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic low_line,
    input  logic light,
    output logic trip
);
    localparam int MAXC = (LIGHT_CYC > NORM_CYC) ? LIGHT_CYC : NORM_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim_m1;

    always_comb begin
        lim_m1 = light ? CW'(LIGHT_CYC - 1) : CW'(NORM_CYC - 1);
        trip   = enable && low_line && (cnt >= lim_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !low_line) cnt <= '0;
        else if (cnt < CW'(MAXC)) cnt <= cnt + 1'b1;
    end

    assert_trip_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> $past(low_line) && $past(enable));
endmodule

// File: rtl/uvlo_soft_ramp.sv
module uvlo_soft_ramp #(
    parameter int SS_W    = 8,
    parameter int STEP_CYC = 3906
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    output logic [SS_W-1:0] level
);
    localparam int PW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre   <= '0;
            level <= '0;
        end else if (pre == PW'(STEP_CYC - 1)) begin
            pre <= '0;
            if (level != {SS_W{1'b1}}) level <= level + 1'b1;
        end else begin
            pre <= pre + 1'b1;
        end
    end

    assert_ss_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> level == '0);
    assert_ss_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> level >= $past(level));
endmodule

// File: rtl/uvlo_seq_fsm.sv
module uvlo_seq_fsm
    import uvlo_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic vdd_above_on,
    input  logic vdd_below_off,
    input  logic vdd_below_recharge,
    input  logic vdd_below_release,
    input  logic vdd_below_acrec,
    input  logic line_above_brownin,
    input  logic fault_latched,
    input  logic bo_trip,
    output logic hv_src_en,
    output logic run_en
);
    seq_state_t state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_CHARGE: if (fault_latched) nxt = ST_LATCH;
                       else if (vdd_above_on && line_above_brownin) nxt = ST_RUN;
            ST_RUN:    if (fault_latched) nxt = ST_LATCH;
                       else if (vdd_below_off) nxt = ST_DRAIN;
                       else if (bo_trip) nxt = ST_BROWN;
            ST_BROWN:  if (fault_latched) nxt = ST_LATCH;
                       else if (vdd_below_off) nxt = ST_DRAIN;
                       else if (line_above_brownin && !vdd_below_acrec) nxt = ST_RUN;
            ST_DRAIN:  if (fault_latched) nxt = ST_LATCH;
                       else if (vdd_below_recharge) nxt = ST_CHARGE;
            ST_LATCH:  if (vdd_below_release) nxt = ST_CHARGE;
            default:   nxt = ST_CHARGE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CHARGE;
        else        state <= nxt;
    end

    always_comb begin
        hv_src_en = 1'b0;
        run_en    = 1'b0;
        unique case (state)
            ST_CHARGE: hv_src_en = 1'b1;
            ST_RUN:    run_en    = 1'b1;
            ST_BROWN, ST_DRAIN, ST_LATCH: ;
            default:   ;
        endcase
    end

    assert_src_run_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(hv_src_en && run_en));
    assert_fault_blocks_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |=> !run_en);
    assert_drain_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_DRAIN && state == ST_CHARGE) |-> $past(vdd_below_recharge));
    assert_run_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_en) |-> $past(line_above_brownin));
    assert_brown_recover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_BROWN && state == ST_RUN) |-> !$past(vdd_below_acrec));
endmodule

// File: rtl/uvlo_startup_seq.sv
module uvlo_startup_seq #(
    parameter int BO_NORM_CYC  = 9_375_000,
    parameter int BO_LIGHT_CYC = 29_375_000,
    parameter int SS_STEP_CYC  = 3906,
    parameter int SS_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vdd_above_on,
    input  logic            vdd_below_off,
    input  logic            vdd_below_recharge,
    input  logic            vdd_below_release,
    input  logic            vdd_below_acrec,
    input  logic            line_above_brownin,
    input  logic            line_below_brownout,
    input  logic            light_load,
    input  logic            fault_latched,
    output logic            hv_src_en,
    output logic            run_en,
    output logic [SS_W-1:0] ss_level
);
    logic bo_trip;

    uvlo_seq_fsm u_fsm (
        .clk, .rst_n, .vdd_above_on, .vdd_below_off, .vdd_below_recharge,
        .vdd_below_release, .vdd_below_acrec, .line_above_brownin,
        .fault_latched, .bo_trip, .hv_src_en, .run_en
    );

    uvlo_brown_debounce #(.NORM_CYC(BO_NORM_CYC), .LIGHT_CYC(BO_LIGHT_CYC)) u_bo (
        .clk, .rst_n, .enable(run_en), .low_line(line_below_brownout),
        .light(light_load), .trip(bo_trip)
    );

    uvlo_soft_ramp #(.SS_W(SS_W), .STEP_CYC(SS_STEP_CYC)) u_ss (
        .clk, .rst_n, .run(run_en), .level(ss_level)
    );
endmodule

// File: tb/tb_uvlo_startup_seq.sv
module tb_uvlo_startup_seq;
    localparam int NB = 20, LB = 60, ST = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic above_on, below_off, below_rch, below_rel, below_acr;
    logic brownin, brownout, light, fault;
    logic src, run;
    logic [7:0] ss;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    uvlo_startup_seq #(.BO_NORM_CYC(NB), .BO_LIGHT_CYC(LB), .SS_STEP_CYC(ST)) dut (
        .clk, .rst_n, .vdd_above_on(above_on), .vdd_below_off(below_off),
        .vdd_below_recharge(below_rch), .vdd_below_release(below_rel),
        .vdd_below_acrec(below_acr), .line_above_brownin(brownin),
        .line_below_brownout(brownout), .light_load(light), .fault_latched(fault),
        .hv_src_en(src), .run_en(run), .ss_level(ss)
    );

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
        if (src && run) begin
            n_fail++;
            $display("FAIL R13 actual=src1_run1 expected=exclusive");
        end
    endtask

    task automatic vdd_high();
        above_on = 1; below_off = 0; below_rch = 0; below_rel = 0; below_acr = 0;
    endtask

    task automatic t_reset();
        above_on = 0; below_off = 1; below_rch = 1; below_rel = 1; below_acr = 1;
        brownin = 0; brownout = 1; light = 0; fault = 0;
        rst_n = 0; cyc(3); rst_n = 1; cyc(1);
        chk("R1 src", src, 1); chk("R1 run", run, 0); chk("R1 ss", ss, 0);
    endtask

    task automatic t_startup();
        vdd_high(); cyc(3);
        chk("R2 no brownin run", run, 0); chk("R2 no brownin src", src, 1);
        brownin = 1; brownout = 0; cyc(1);
        chk("R2 run", run, 1); chk("R2 src", src, 0);
    endtask

    task automatic t_ramp();
        cyc(3 * ST);
        chk("R10 step", ss, 3);
        cyc(256 * ST);
        chk("R10 saturate", ss, 255);
    endtask

    task automatic t_glitch();
        brownin = 0; brownout = 1; cyc(NB - 1);
        brownout = 0; brownin = 1; cyc(1);
        chk("R7 glitch run", run, 1); chk("R7 ss kept", ss, 255);
        brownout = 1; brownin = 0; cyc(NB - 1);
        chk("R7 restart count", run, 1);
        brownout = 0; brownin = 1; cyc(1);
    endtask

    task automatic t_brown_norm();
        brownin = 0; brownout = 1; cyc(NB - 1);
        chk("R5 before window", run, 1);
        cyc(1);
        chk("R5 trip", run, 0); chk("R5 src off", src, 0);
        cyc(1);
        chk("R11 ss clear", ss, 0);
        below_acr = 1; brownin = 1; brownout = 0; cyc(3);
        chk("R8 acrec blocks", run, 0);
        below_acr = 0; cyc(1);
        chk("R8 recover", run, 1); chk("R10 restart", ss, 0);
        cyc(ST);
        chk("R10 first step", ss, 1);
    endtask

    task automatic t_light();
        light = 1; brownin = 0; brownout = 1; cyc(NB);
        chk("R6 not at normal window", run, 1);
        cyc(LB - NB - 1);
        chk("R6 before light window", run, 1);
        cyc(1);
        chk("R6 trip", run, 0);
        below_off = 1; below_acr = 1; cyc(1);
        below_acr = 0; brownin = 1; cyc(1);
        chk("R9 drain", run, 0); chk("R9 src off", src, 0);
        light = 0; brownout = 0;
        cyc(5);
        chk("R4 src held off", src, 0);
        below_rch = 1; cyc(1);
        chk("R4 recharge", src, 1);
    endtask

    task automatic t_uvlo();
        vdd_high(); cyc(1);
        chk("R2 rerun", run, 1);
        below_off = 1; cyc(1);
        chk("R3 run off", run, 0); chk("R3 src off", src, 0);
        above_on = 0; below_off = 0; cyc(3);
        chk("R4 wait recharge", src, 0);
    endtask

    task automatic t_fault();
        below_rch = 1; cyc(1);
        vdd_high(); cyc(1);
        chk("R12 pre run", run, 1);
        fault = 1; cyc(1);
        chk("R12 run off", run, 0); chk("R12 src off", src, 0);
        fault = 0; below_rch = 1; cyc(5);
        chk("R12 held", run, 0); chk("R12 src held", src, 0);
        below_rel = 1; cyc(1);
        chk("R12 release", src, 1);
    endtask

    initial begin
        t_reset();
        t_startup();
        t_ramp();
        t_glitch();
        t_brown_norm();
        t_light();
        t_uvlo();
        t_fault();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule